// File: doc/BRIEF.md
# Byte-Written Output Compare Unit

This block watches a free-running 16-bit counter and fires once when the counter reaches a programmed 16-bit compare value. On that event it drives an output pin to the level held in a level-control input and raises a compare flag. The compare value is loaded through an 8-bit register bus as two bytes. The high byte sits at address 0x16 and the low byte at 0x17. Both bytes read back through the same bus.

The unit guards against comparing against a half-written value. Once the high byte is written, matching stays off until the low byte is written. The flag clears only through a two-step handshake. First the status register is read while the flag is set. Then the low compare byte is read or written. The compare registers are not reset, so their contents survive a reset. The counter itself, any prescaler and interrupt masking all live outside this block.

Top module: `ocmp_unit`

## Requirements
- R1: When the counter first equals the compare value while matching is enabled, the flag reads 1 and the pin takes the level-control value after the next rising clock edge. The pin does not change in any cycle without a match.
- R2: A match with the level-control input at 0 drives the pin low, and a match with it at 1 drives the pin high.
- R3: A write to the high byte (address 0x16) disables matching until the low byte (address 0x17) is written. While matching is disabled, a counter equal to the compare value sets no flag.
- R4: The flag clears only when a status-read strobe taken while the flag is 1 is followed, in a later cycle, by a read or a write of the low byte at 0x17. A low-byte access without that earlier status read leaves the flag at 1.
- R5: If a match and a clearing low-byte access fall in the same cycle, the flag stays 1.
- R6: A read at 0x16 returns the stored high byte, bits 15..8 of the compare value. A read at 0x17 returns the stored low byte, bits 7..0. A read at any other address returns 0.
- R7: Reset drives the flag and the pin to 0 and leaves both compare bytes unchanged.
- R8: A match is taken once per arrival of the counter at the compare value. A counter that stays equal to it does not set the flag again after the flag has been cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address and strobe |
| count_in | input | 16 | Free-running counter value |
| level_in | input | 1 | Level the pin takes on a match |
| stat_rd | input | 1 | Strobe marking a read of the timer status register |
| cmp_pin | output | 1 | Compare output pin |
| cmp_flag | output | 1 | Compare flag |

## Verification
A match can set the flag in the same cycle that a low-byte access would clear it. To provoke this, the bench first raises the flag and takes a status read. On one falling edge it then moves the counter onto the compare value and issues a low-byte read. After the rising edge the flag must still read 1. Two related cases are also checked: a lone low-byte access must not clear the flag, and a counter held on the compare value must not set the flag again after it has been cleared.

// File: rtl/ocmp_pkg.sv
// Package: shared types for the output compare unit.
// Assumes: one register access per strobe cycle.
package ocmp_pkg;

    // Decoded access to one compare byte lane.
    typedef struct packed {
        logic rd;
        logic wr;
    } lane_acc_t;

    // Decode a bus access into a lane access.
    function automatic lane_acc_t lane_decode(input logic hit, input logic wr);
        lane_acc_t a;
        a.rd = hit & ~wr;
        a.wr = hit & wr;
        return a;
    endfunction

endpackage

// File: rtl/ocmp_regs.sv
// Module: ocmp_regs
// Holds the compare value as byte lanes on the register bus. The lane
// holding the top byte is at BASE_ADDR and the lowest lane is at the
// highest address. A write to the top lane suspends matching and a write
// to lane 0 resumes it. The compare bytes have no reset.
// Assumes: CNT_W is a multiple of DATA_W.
module ocmp_regs
    import ocmp_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int CNT_W     = 16,
    parameter int BASE_ADDR = 'h16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [CNT_W-1:0]  cmp_val,
    output logic              armed,
    output logic              lo_access
);
    localparam int NB = CNT_W / DATA_W;

    logic [DATA_W-1:0] lane_q  [NB];
    logic [DATA_W-1:0] lane_rd [NB];
    logic [NB-1:0]     lane_hit;
    lane_acc_t         acc     [NB];

    for (genvar k = 0; k < NB; k++) begin : g_lane
        localparam int LANE_ADDR = BASE_ADDR + (NB - 1 - k);

        // Address match for this lane.
        assign lane_hit[k] = bus_sel && (bus_addr == ADDR_W'(LANE_ADDR));
        assign acc[k]      = lane_decode(lane_hit[k], bus_wr);

        // Store the byte on a write; the lane keeps its value through reset.
        always_ff @(posedge clk) begin
            if (acc[k].wr) begin
                lane_q[k] <= bus_wdata;
            end
        end

        // Read data from this lane, zero when the lane is not addressed.
        assign lane_rd[k] = acc[k].rd ? lane_q[k] : '0;
        assign cmp_val[k*DATA_W +: DATA_W] = lane_q[k];
    end

    // Merge the lane read data onto the bus.
    always_comb begin
        bus_rdata = '0;
        for (int k = 0; k < NB; k++) begin
            bus_rdata = bus_rdata | lane_rd[k];
        end
    end

    // Matching is enabled from reset, off after a top-lane write, back on after a lane-0 write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b1;
        end else if (acc[0].wr) begin
            armed <= 1'b1;
        end else if (acc[NB-1].wr) begin
            armed <= 1'b0;
        end
    end

    assign lo_access = lane_hit[0];

    AST_HI_WRITE_SUSPENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc[NB-1].wr && !acc[0].wr) |=> !armed) else $error("high write did not suspend"); // R3
    AST_LO_WRITE_RESUMES: assert property (@(posedge clk) disable iff (!rst_n)
        acc[0].wr |=> armed) else $error("low write did not resume"); // R3

endmodule

// File: rtl/ocmp_match.sv
// Module: ocmp_match
// Compares the counter with the compare value and gives a one-cycle
// pulse in the first cycle the two are equal while matching is enabled.
// Assumes: count_in comes from a register in the same clock domain.
module ocmp_match #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_in,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             armed,
    output logic             match_pulse
);
    logic eq_now;
    logic eq_prev;

    // Equality, gated by the matching enable.
    assign eq_now = armed && (count_in == cmp_val);

    // Keep the previous equality so a steady counter does not retrigger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eq_prev <= 1'b0;
        end else begin
            eq_prev <= eq_now;
        end
    end

    assign match_pulse = eq_now && !eq_prev;

    AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |=> !match_pulse) else $error("match retriggered"); // R8
    AST_SUSPENDED_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> !match_pulse) else $error("match while suspended"); // R3

endmodule

// File: rtl/ocmp_flag.sv
// Module: ocmp_flag
// Keeps the compare flag and the compare pin. A match sets the flag and
// drives the pin to the level input. The flag clears after a status read
// taken while it is set, followed by a later low-byte access. A set in
// the same cycle as a clear wins.
// Assumes: stat_rd and lo_access are one-cycle strobes.
module ocmp_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic match,
    input  logic stat_rd,
    input  logic lo_access,
    input  logic level_in,
    output logic flag_q,
    output logic pin_q
);
    logic clr_arm;
    logic clr_now;

    assign clr_now = lo_access && clr_arm;

    // Remember a status read seen while the flag was set; a low access consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_arm <= 1'b0;
        end else if (stat_rd && flag_q) begin
            clr_arm <= 1'b1;
        end else if (lo_access) begin
            clr_arm <= 1'b0;
        end
    end

    // Flag: a match sets it, the armed low access clears it, and a set beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (match) begin
            flag_q <= 1'b1;
        end else if (clr_now) begin
            flag_q <= 1'b0;
        end
    end

    // Pin takes the level input on a match and holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q <= 1'b0;
        end else if (match) begin
            pin_q <= level_in;
        end
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> flag_q) else $error("match did not set flag"); // R5
    AST_CLEAR_NEEDS_LO: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q) |-> $past(lo_access)) else $error("flag cleared without low access"); // R4
    AST_PIN_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> (pin_q == $past(level_in))) else $error("pin level wrong"); // R2
    AST_PIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !match |=> $stable(pin_q)) else $error("pin moved without match"); // R1

endmodule

// File: rtl/ocmp_unit.sv
// Module: ocmp_unit (top)
// Output compare unit: compare value loaded as bytes over the register
// bus, matched against a free-running counter, driving a pin and a flag.
// Assumes: the counter, prescaler and interrupt masking live outside.
module ocmp_unit #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int CNT_W     = 16,
    parameter int BASE_ADDR = 'h16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  count_in,
    input  logic              level_in,
    input  logic              stat_rd,
    output logic              cmp_pin,
    output logic              cmp_flag
);
    logic [CNT_W-1:0] cmp_val;
    logic             armed;
    logic             lo_access;
    logic             match_pulse;

    ocmp_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .BASE_ADDR(BASE_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cmp_val(cmp_val), .armed(armed), .lo_access(lo_access)
    );

    ocmp_match #(.CNT_W(CNT_W)) u_match (
        .clk(clk), .rst_n(rst_n), .count_in(count_in), .cmp_val(cmp_val),
        .armed(armed), .match_pulse(match_pulse)
    );

    ocmp_flag u_flag (
        .clk(clk), .rst_n(rst_n), .match(match_pulse), .stat_rd(stat_rd),
        .lo_access(lo_access), .level_in(level_in), .flag_q(cmp_flag),
        .pin_q(cmp_pin)
    );

    AST_FLAG_RESET_LOW: assert property (@(posedge clk)
        !rst_n |=> (!cmp_flag && !cmp_pin)) else $error("reset state wrong"); // R7

endmodule

// File: tb/tb_ocmp_unit.sv
module tb_ocmp_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_sel, bus_wr;
    logic [7:0]  bus_addr, bus_wdata, bus_rdata;
    logic [15:0] count_in;
    logic        level_in, stat_rd;
    logic        cmp_pin, cmp_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    ocmp_unit dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .count_in(count_in), .level_in(level_in), .stat_rd(stat_rd),
        .cmp_pin(cmp_pin), .cmp_flag(cmp_flag)
    );

    // Row fields: [34:19] compare, [18:3] counter, [2] level, [1] flag, [0] pin
    localparam logic [34:0] VEC [6] = '{
        {16'h1234, 16'h1234, 1'b1, 1'b1, 1'b1},
        {16'h1234, 16'h1235, 1'b0, 1'b0, 1'b1},
        {16'hABCD, 16'hABCD, 1'b0, 1'b1, 1'b0},
        {16'hFFFF, 16'hFFFF, 1'b1, 1'b1, 1'b1},
        {16'h0000, 16'h0001, 1'b0, 1'b0, 1'b1},
        {16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic status_read();
        @(negedge clk);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    task automatic clear_flag();
        logic [7:0] d;
        status_read();
        bus_read(8'h17, d);
    endtask

    initial begin
        logic [7:0] rd;
        rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        count_in = 16'h5555; level_in = 1'b0; stat_rd = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7 reset flag", 16'(cmp_flag), 16'h0);
        chk("R7 reset pin", 16'(cmp_pin), 16'h0);

        // Table walk: R1 and R2 matches, near-miss rows
        for (int i = 0; i < 6; i++) begin
            logic [15:0] cv, cn;
            cv = VEC[i][34:19];
            cn = VEC[i][18:3];
            count_in = ~cv;
            bus_write(8'h16, cv[15:8]);
            bus_write(8'h17, cv[7:0]);
            level_in = VEC[i][2];
            clear_flag();
            @(negedge clk);
            count_in = cn;
            @(negedge clk);
            count_in = ~cv;
            chk($sformatf("R1 row %0d flag", i), 16'(cmp_flag), 16'(VEC[i][1]));
            chk($sformatf("R2 row %0d pin", i), 16'(cmp_pin), 16'(VEC[i][0]));
        end

        // R3: a high write suspends matching until the low write
        clear_flag();
        count_in = 16'h5555;
        level_in = 1'b1;
        bus_write(8'h17, 8'h22);
        bus_write(8'h16, 8'h22);
        count_in = 16'h2222;
        repeat (3) @(negedge clk);
        chk("R3 suspended no flag", 16'(cmp_flag), 16'h0);
        count_in = 16'h5555;
        bus_write(8'h17, 8'h22);
        count_in = 16'h2222;
        @(negedge clk);
        chk("R3 resumed flag", 16'(cmp_flag), 16'h1);
        chk("R1 pin high", 16'(cmp_pin), 16'h1);

        // R4: a low access with no status read does not clear
        bus_read(8'h17, rd);
        @(negedge clk);
        chk("R4 lone low read keeps flag", 16'(cmp_flag), 16'h1);
        status_read();
        bus_write(8'h17, 8'h22);
        chk("R4 status then low write clears", 16'(cmp_flag), 16'h0);

        // R8: counter held on the compare value does not retrigger
        repeat (4) @(negedge clk);
        chk("R8 steady counter no retrigger", 16'(cmp_flag), 16'h0);

        // R5: match and clearing access in one cycle, set wins
        count_in = 16'h5555;
        @(negedge clk);
        count_in = 16'h2222;
        @(negedge clk);
        count_in = 16'h5555;
        chk("R5 flag raised", 16'(cmp_flag), 16'h1);
        status_read();
        @(negedge clk);
        count_in = 16'h2222;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'h17;
        @(negedge clk);
        bus_sel = 1'b0;
        count_in = 16'h5555;
        chk("R5 set wins over clear", 16'(cmp_flag), 16'h1);

        // R6: readback and unmapped address
        bus_write(8'h16, 8'h9A);
        bus_write(8'h17, 8'h3C);
        bus_read(8'h16, rd);
        chk("R6 high readback", 16'(rd), 16'h009A);
        bus_read(8'h17, rd);
        chk("R6 low readback", 16'(rd), 16'h003C);
        bus_read(8'h18, rd);
        chk("R6 unmapped reads zero", 16'(rd), 16'h0);

        // R7: reset clears flag and pin, keeps compare bytes
        level_in = 1'b1;
        count_in = 16'h9A3C;
        @(negedge clk);
        count_in = 16'h5555;
        chk("R7 pre-reset flag", 16'(cmp_flag), 16'h1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7 flag after reset", 16'(cmp_flag), 16'h0);
        chk("R7 pin after reset", 16'(cmp_pin), 16'h0);
        bus_read(8'h16, rd);
        chk("R7 high kept", 16'(rd), 16'h009A);
        bus_read(8'h17, rd);
        chk("R7 low kept", 16'(rd), 16'h003C);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule